// File: doc/BRIEF.md
# Dithered-Frequency PWM Timebase

This block is the digital oscillator of a switching power controller. It runs from a fast reference clock and divides it into switching periods. Each period begins with a one-cycle start strobe, and a ramp count runs from zero up to the period length minus one. That ramp can drive a slope-compensation generator. A flag rises once the ramp passes the maximum-duty point of the current period. Two windows open at the start of every period: a short blanking window, during which current-sense trips are to be ignored, and a minimum on-time window.

To spread switching energy across the spectrum, the period length can be swept by a triangular dither. At each period boundary the offset from the centre length moves by one fixed step. It reverses at plus and minus the dither depth. With the defaults at a 100 MHz reference, the centre is 1538 cycles (about 65 kHz) and the depth is 108 cycles (about 7 %). A step of 2 gives an envelope of 216 periods, roughly 3.3 ms. The maximum-duty point is recomputed from each new period length, so the duty limit stays at three quarters of the period across the whole sweep. When dither is off, every period has the centre length.

Top module: `dither_pwm_timebase`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, ramp is 0, period_start is 1, blank is 1 and dmax_expired is 0. The first period after reset lasts exactly CENTER cycles.
- R2: ramp rises by one every cycle from 0 to L-1, where L is the current period length, and then returns to 0. period_start is 1 exactly in the cycles where ramp is 0.
- R3: When dither_en is low at every period boundary, every period lasts exactly CENTER cycles.
- R4: DEPTH must be a multiple of STEP. While dither_en stays high, consecutive period lengths differ by exactly STEP. The lengths start at CENTER, first rise, and turn around at CENTER+DEPTH and CENTER-DEPTH, so both extremes are reached and never exceeded.
- R5: dither_en is sampled in the last cycle of each period. If it is low there, the next period lasts CENTER cycles. If it is high there after a disabled period, the next period lasts CENTER+STEP cycles, because the sweep restarts upward from zero offset.
- R6: dmax_expired is 1 exactly when ramp >= floor(L*DUTY_NUM/2^DUTY_SHIFT) for the current period length L. The defaults give three quarters of the period.
- R7: blank is 1 exactly when ramp < BLANK_CYC.
- R8: minon_win is 1 exactly when ramp < MINON_CYC. MINON_CYC >= BLANK_CYC, so minon_win is always 1 while blank is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| dither_en | input | 1 | High enables the triangular period sweep |
| period_start | output | 1 | One-cycle strobe on the first cycle of each period |
| ramp | output | RW = clog2(CENTER+DEPTH+1) | Cycle count within the current period |
| dmax_expired | output | 1 | Maximum-duty point of this period reached |
| blank | output | 1 | Leading-edge blanking window |
| minon_win | output | 1 | Minimum on-time window |

## Verification
The bench builds the block with CENTER=100, DEPTH=8, STEP=2, BLANK_CYC=3 and MINON_CYC=6, and keeps the three-quarter duty. A full dither envelope then takes only 16 periods, so one short run reaches both sweep extremes and both turnaround points, along with several enable and disable boundaries. Period lengths between 92 and 108 give maximum-duty points from 69 to 81, so the change of duty threshold with period length is seen at every step. Reset is also applied in the middle of a period.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

    typedef enum logic {
        SWEEP_UP   = 1'b0,
        SWEEP_DOWN = 1'b1
    } sweep_dir_e;

    typedef struct packed {
        logic blank;
        logic minon;
        logic dmax_hit;
    } win_flags_t;

    // Duty-limit count for a period of len cycles: len * num / 2^shift, rounded down.
    function automatic int duty_limit(int len, int num, int shift);
        return (len * num) >>> shift;
    endfunction

    // Bits needed to hold values 0..maxval.
    function automatic int span_bits(int maxval);
        return $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/dpt_triangle.sv
module dpt_triangle
    import dpt_pkg::*;
#(
    parameter int DEPTH = 108,
    parameter int STEP  = 2,
    parameter int OW    = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 advance,
    input  logic                 enable,
    output logic signed [OW-1:0] off_next
);
    localparam logic signed [OW-1:0] DEPTH_S = OW'(DEPTH);
    localparam logic signed [OW-1:0] STEP_S  = OW'(STEP);

    logic signed [OW-1:0] off_q;
    sweep_dir_e           dir_q;
    sweep_dir_e           dir_next;

    // The next offset is the one the coming period will use.
    always_comb begin
        off_next = off_q;
        dir_next = dir_q;
        if (!enable) begin
            off_next = '0;
            dir_next = SWEEP_UP;
        end else if (dir_q == SWEEP_UP) begin
            if (off_q > (DEPTH_S - STEP_S)) begin
                off_next = off_q - STEP_S;
                dir_next = SWEEP_DOWN;
            end else begin
                off_next = off_q + STEP_S;
            end
        end else begin
            if (off_q < (STEP_S - DEPTH_S)) begin
                off_next = off_q + STEP_S;
                dir_next = SWEEP_UP;
            end else begin
                off_next = off_q - STEP_S;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= '0;
            dir_q <= SWEEP_UP;
        end else if (advance) begin
            off_q <= off_next;
            dir_q <= dir_next;
        end
    end

endmodule

// File: rtl/dpt_period_cnt.sv
module dpt_period_cnt
    import dpt_pkg::*;
#(
    parameter int CENTER     = 1538,
    parameter int DUTY_NUM   = 3,
    parameter int DUTY_SHIFT = 2,
    parameter int RW         = 11,
    parameter int OW         = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [OW-1:0] off_next,
    output logic [RW-1:0]        ramp_q,
    output logic [RW-1:0]        len_q,
    output logic [RW-1:0]        dmax_q,
    output logic                 wrap,
    output logic                 start
);
    localparam logic [RW-1:0] LEN_RST  = RW'(CENTER);
    localparam logic [RW-1:0] DMAX_RST = RW'(duty_limit(CENTER, DUTY_NUM, DUTY_SHIFT));

    int            next_len_i;
    logic [RW-1:0] len_next;
    logic [RW-1:0] dmax_next;

    always_comb begin
        next_len_i = CENTER + int'(off_next);
        len_next   = RW'(next_len_i);
        dmax_next  = RW'(duty_limit(next_len_i, DUTY_NUM, DUTY_SHIFT));
    end

    assign wrap  = (ramp_q == (len_q - RW'(1)));
    assign start = (ramp_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ramp_q <= '0;
            len_q  <= LEN_RST;
            dmax_q <= DMAX_RST;
        end else if (wrap) begin
            ramp_q <= '0;
            len_q  <= len_next;
            dmax_q <= dmax_next;
        end else begin
            ramp_q <= ramp_q + RW'(1);
        end
    end

endmodule

// File: rtl/dpt_window.sv
module dpt_window
    import dpt_pkg::*;
#(
    parameter int RW        = 11,
    parameter int BLANK_CYC = 25,
    parameter int MINON_CYC = 35
) (
    input  logic [RW-1:0] ramp,
    input  logic [RW-1:0] dmax,
    output win_flags_t    flags
);
    always_comb begin
        flags.blank    = (ramp < RW'(BLANK_CYC));
        flags.minon    = (ramp < RW'(MINON_CYC));
        flags.dmax_hit = (ramp >= dmax);
    end

endmodule

// File: rtl/dither_pwm_timebase.sv
module dither_pwm_timebase
    import dpt_pkg::*;
#(
    parameter int CENTER     = 1538,
    parameter int DEPTH      = 108,
    parameter int STEP       = 2,
    parameter int DUTY_NUM   = 3,
    parameter int DUTY_SHIFT = 2,
    parameter int BLANK_CYC  = 25,
    parameter int MINON_CYC  = 35,
    localparam int RW        = span_bits(CENTER + DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dither_en,
    output logic          period_start,
    output logic [RW-1:0] ramp,
    output logic          dmax_expired,
    output logic          blank,
    output logic          minon_win
);
    localparam int OW = span_bits(DEPTH + STEP) + 1;

    logic signed [OW-1:0] off_next;
    logic [RW-1:0]        len_q;
    logic [RW-1:0]        dmax_q;
    logic                 wrap;
    win_flags_t           flags;

    dpt_triangle #(
        .DEPTH (DEPTH),
        .STEP  (STEP),
        .OW    (OW)
    ) u_tri (
        .clk      (clk),
        .rst      (rst),
        .advance  (wrap),
        .enable   (dither_en),
        .off_next (off_next)
    );

    dpt_period_cnt #(
        .CENTER     (CENTER),
        .DUTY_NUM   (DUTY_NUM),
        .DUTY_SHIFT (DUTY_SHIFT),
        .RW         (RW),
        .OW         (OW)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .off_next (off_next),
        .ramp_q   (ramp),
        .len_q    (len_q),
        .dmax_q   (dmax_q),
        .wrap     (wrap),
        .start    (period_start)
    );

    dpt_window #(
        .RW        (RW),
        .BLANK_CYC (BLANK_CYC),
        .MINON_CYC (MINON_CYC)
    ) u_win (
        .ramp  (ramp),
        .dmax  (dmax_q),
        .flags (flags)
    );

    assign blank        = flags.blank;
    assign minon_win    = flags.minon;
    assign dmax_expired = flags.dmax_hit;

endmodule

// File: rtl/dpt_checker.sv
module dpt_checker #(
    parameter int RW     = 11,
    parameter int CENTER = 1538,
    parameter int DEPTH  = 108
) (
    input logic          clk,
    input logic          rst,
    input logic [RW-1:0] ramp,
    input logic          blank,
    input logic          minon,
    input logic          dmax,
    input logic [RW-1:0] len
);
    // R2
    ramp_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (ramp != '0) |-> (ramp == $past(ramp) + 1'b1));

    // R2
    ramp_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        ((ramp == '0) && !$past(rst)) |-> ($past(ramp) == $past(len) - 1'b1));

    // R4
    len_range_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(len) >= CENTER - DEPTH) && (int'(len) <= CENTER + DEPTH));

    // R6
    dmax_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(dmax) && (ramp != '0)) |-> dmax);

    // R6
    dmax_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ramp == '0) |-> !dmax);

    // R7
    blank_open_chk: assert property (@(posedge clk) disable iff (rst)
        (ramp == '0) |-> blank);

    // R8
    minon_cover_chk: assert property (@(posedge clk) disable iff (rst)
        blank |-> minon);

endmodule

bind dither_pwm_timebase dpt_checker #(
    .RW     (RW),
    .CENTER (CENTER),
    .DEPTH  (DEPTH)
) u_dpt_chk (
    .clk   (clk),
    .rst   (rst),
    .ramp  (ramp),
    .blank (blank),
    .minon (minon_win),
    .dmax  (dmax_expired),
    .len   (len_q)
);

// File: tb/tb_dither_pwm_timebase.sv
module tb_dither_pwm_timebase;
    localparam int C  = 100;
    localparam int D  = 8;
    localparam int S  = 2;
    localparam int BL = 3;
    localparam int MO = 6;
    localparam int DN = 3;
    localparam int DS = 2;
    localparam int RW = $clog2(C + D + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic          ps, dmx, blk, mon;
    logic [RW-1:0] ramp;

    dither_pwm_timebase #(
        .CENTER(C), .DEPTH(D), .STEP(S), .DUTY_NUM(DN), .DUTY_SHIFT(DS),
        .BLANK_CYC(BL), .MINON_CYC(MO)
    ) dut (
        .clk(clk), .rst(rst), .dither_en(en), .period_start(ps),
        .ramp(ramp), .dmax_expired(dmx), .blank(blk), .minon_win(mon)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int m_ramp, m_len, m_k;
    int since, last_len, prev_len, lmin, lmax;

    // Triangle offset for the k-th period since the sweep (re)started.
    function automatic int tri_off(int k);
        int n, p;
        n = D / S;
        p = k % (4 * n);
        if (p <= n)          return p * S;
        else if (p <= 3 * n) return (2 * n - p) * S;
        else                 return (p - 4 * n) * S;
    endfunction

    function automatic int duty_of(int len);
        return (len * DN) / (1 << DS);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic advance_model();
        if (m_ramp == m_len - 1) begin
            m_ramp = 0;
            m_k    = en ? m_k + 1 : 0;
            m_len  = C + tri_off(m_k);
        end else begin
            m_ramp++;
        end
    endtask

    task automatic cycle();
        @(negedge clk);
        chk(int'(ramp) == m_ramp, "R2 ramp", int'(ramp), m_ramp);
        chk(ps == (m_ramp == 0), "R2 period_start", int'(ps), int'(m_ramp == 0));
        chk(dmx == (m_ramp >= duty_of(m_len)), "R6 dmax_expired", int'(dmx), int'(m_ramp >= duty_of(m_len)));
        chk(blk == (m_ramp < BL), "R7 blank", int'(blk), int'(m_ramp < BL));
        chk(mon == (m_ramp < MO), "R8 minon_win", int'(mon), int'(m_ramp < MO));
        since++;
        if (ps) begin
            last_len = since;
            since    = 0;
            if (last_len < lmin) lmin = last_len;
            if (last_len > lmax) lmax = last_len;
        end
        advance_model();
    endtask

    task automatic wait_strobes(int n);
        int got = 0;
        while (got < n) begin
            cycle();
            if (ps) got++;
        end
    endtask

    task automatic reset_seq(int n);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(ramp == '0, "R1 ramp in reset", int'(ramp), 0);
            chk(ps == 1'b1, "R1 strobe in reset", int'(ps), 1);
            chk(blk == 1'b1, "R1 blank in reset", int'(blk), 1);
            chk(dmx == 1'b0, "R1 dmax in reset", int'(dmx), 0);
        end
        rst    = 1'b0;
        m_ramp = 0;
        m_len  = C;
        m_k    = 0;
        since  = 0;
        advance_model();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all): actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        lmin = 1 << 20;
        lmax = 0;
        reset_seq(3);

        // R1: first period is CENTER long.
        en = 1'b1;
        wait_strobes(1);
        chk(last_len == C, "R1 first period", last_len, C);

        // R4: full sweep with dither held on.
        lmin = 1 << 20;
        lmax = 0;
        prev_len = last_len;
        for (int i = 0; i < 4 * (D / S) + 4; i++) begin
            wait_strobes(1);
            chk((last_len - prev_len == S) || (prev_len - last_len == S),
                "R4 step size", last_len - prev_len, S);
            prev_len = last_len;
        end
        chk(lmax == C + D, "R4 upper extreme", lmax, C + D);
        chk(lmin == C - D, "R4 lower extreme", lmin, C - D);

        // R5 / R3: disable mid-period.
        repeat (17) cycle();
        en = 1'b0;
        wait_strobes(1);
        wait_strobes(1);
        chk(last_len == C, "R5 disable returns to centre", last_len, C);
        for (int i = 0; i < 3; i++) begin
            wait_strobes(1);
            chk(last_len == C, "R3 fixed centre period", last_len, C);
        end

        // R5: re-enable restarts the sweep upward.
        repeat (10) cycle();
        en = 1'b1;
        wait_strobes(1);
        chk(last_len == C, "R5 period before restart", last_len, C);
        wait_strobes(1);
        chk(last_len == C + S, "R5 restart upward", last_len, C + S);

        // Random enable toggling, checked every cycle against the model.
        for (int i = 0; i < 6000; i++) begin
            cycle();
            if ($urandom % 150 == 0) en = ~en;
        end

        // R1: reset in mid-period and again in mid-sweep.
        repeat (37) cycle();
        reset_seq(2);
        en = 1'b1;
        wait_strobes(1);
        chk(last_len == C, "R1 first period after reset", last_len, C);
        wait_strobes(1);
        chk(last_len == C + S, "R4 first step after reset", last_len, C + S);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule